// File: doc/BRIEF.md
# MMU Control Register File

This block holds the software-visible control and status words that sit next to a translation lookaside buffer. It stores the MMU control word and the three page-table-entry staging words: high, low and assist. It also stores the translation table base, the faulting address, and three event-code words: trap code, exception event and interrupt event. Each word keeps only the bits it is allowed to hold. The TLB array and the page walker live outside the block. They read the stored words from dedicated output pins and react to two single-cycle pulses: one that invalidates every TLB entry, and one that flushes cached translations when the address-space identifier changes.

Software reaches the words through a simple register port. One access is presented per cycle with `acc_en`, and the port is never back-pressured: every access is taken in the cycle it is presented. Read data and the error strobe are combinational in that same cycle. Writes take effect at the next clock edge. The pulses are registered, so they are high for exactly the one cycle that follows the accepted write. The control and status pins (pulses and stored words) are plain levels with no handshake.

Top module: `mmu_crf`

## Requirements
- R1: After reset every stored word reads 0 and neither `tlb_inval_pulse` nor `asid_flush_pulse` is high.
- R2: A legal write to the control word with bit 2 set raises `tlb_inval_pulse` for the cycle after the write edge. Bit 2 is stored as 0, and every other bit of the control word is stored as written.
- R3: A legal write to the control word with bit 2 clear produces no invalidate pulse.
- R4: A legal write to the entry-high word stores all 32 bits. It raises `asid_flush_pulse` for the cycle after the write edge only when the written bits 7:0 differ from the stored bits 7:0; writing the same identifier again produces no pulse.
- R5: The entry-assist word keeps written bits 3:0 and reads 0 above them.
- R6: The trap-code, exception-event and interrupt-event words each keep written bits 10:0 and read 0 above them.
- R7: The entry-low, table-base and fault-address words store all 32 written bits.
- R8: The access size is encoded 0 = byte, 1 = half word, 2 = word, 3 = reserved. Any access whose size is not word raises `acc_err` in the same cycle, returns read data 0, changes no stored word and produces no pulse.
- R9: An access to an offset that is not a multiple of 4, or that is above 0x20, raises `acc_err`, returns read data 0, changes no stored word and produces no pulse.
- R10: A legal word read returns the stored word in the same cycle. The byte offsets are: control 0x00, entry-high 0x04, entry-low 0x08, entry-assist 0x0C, table base 0x10, fault address 0x14, trap code 0x18, exception event 0x1C, interrupt event 0x20.
- R11: Each pulse is high for one cycle only, unless another qualifying write follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An access is presented this cycle (always accepted) |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code (2 = word is the only legal size) |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, 0 unless a legal read |
| acc_err | output | 1 | Access was illegal (size or offset) |
| tlb_inval_pulse | output | 1 | One-cycle invalidate-all request to the TLB |
| asid_flush_pulse | output | 1 | One-cycle flush request on an identifier change |
| mmu_ctrl | output | 32 | Stored control word |
| pte_high | output | 32 | Stored entry-high word |
| pte_low | output | 32 | Stored entry-low word |
| pte_assist | output | 32 | Stored entry-assist word |
| table_base | output | 32 | Stored translation table base |

## Verification
The bench walks a single one and a single zero through all 32 bits of every word. Its reference model masks each value arithmetically, so a wrong keep mask shows up as a readback mismatch on the exact bit that leaked or was lost. Writes to the entry-high word are chosen to both change and repeat the identifier byte. A flush pulse that fired on every write, or that compared the wrong byte, would then pulse when none is expected. Every word is also hit with byte, half-word and reserved sizes, and the bench sweeps misaligned offsets and offsets past the map. A decoder that ignored size or alignment would corrupt a stored word or fire a pulse that the next legal read exposes.

// File: rtl/mmu_crf_pkg.sv
package mmu_crf_pkg;
  localparam int DW        = 32;
  localparam int NREG      = 9;
  localparam int INVAL_BIT = 2;
  localparam int ASID_W    = 8;
  localparam int ASSIST_W  = 4;
  localparam int EVENT_W   = 11;

  typedef enum logic [3:0] {
    IDX_CTRL  = 4'd0,
    IDX_PTEH  = 4'd1,
    IDX_PTEL  = 4'd2,
    IDX_PTEA  = 4'd3,
    IDX_TBASE = 4'd4,
    IDX_FAULT = 4'd5,
    IDX_TRAP  = 4'd6,
    IDX_EXCEV = 4'd7,
    IDX_IRQEV = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Bits a word may hold after a write.
  function automatic logic [DW-1:0] keep_mask(input int idx);
    logic [DW-1:0] m;
    case (idx)
      int'(IDX_CTRL):  m = ~(DW'(1) << INVAL_BIT);
      int'(IDX_PTEA):  m = (DW'(1) << ASSIST_W) - DW'(1);
      int'(IDX_TRAP),
      int'(IDX_EXCEV),
      int'(IDX_IRQEV): m = (DW'(1) << EVENT_W) - DW'(1);
      default:         m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mmu_crf_decode.sv
module mmu_crf_decode
  import mmu_crf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NREG-1:0]   wr_sel,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic              acc_err
);
  logic aligned, in_map, is_word, hit;

  assign rd_idx  = acc_addr[ADDR_W-1:2];
  assign aligned = (acc_addr[1:0] == 2'b00);
  assign in_map  = (rd_idx < IDX_W'(NREG));
  assign is_word = (acc_size == SZ_WORD);
  assign hit     = acc_en && aligned && in_map && is_word;
  assign acc_err = acc_en && !hit;
  assign rd_hit  = hit && !acc_wr;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = hit && acc_wr && (rd_idx == IDX_W'(i));
  end

  // R8/R9: an illegal access never selects a word for writing
  assert_err_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (wr_sel == '0));
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/mmu_crf_regs.sv
module mmu_crf_regs
  import mmu_crf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          wr_sel,
  input  logic [DW-1:0]            wdata,
  input  logic                     rd_hit,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [NREG-1:0][DW-1:0]  reg_q,
  output logic [DW-1:0]            rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_sel[i]) reg_q[i] <= wdata & keep_mask(i);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit && (rd_idx == IDX_W'(i))) rdata = reg_q[i];
    end
  end

  assert_assist_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[IDX_PTEA] |=> (reg_q[IDX_PTEA] == ($past(wdata) & 32'h0000_000F)));
  assert_trap_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[IDX_TRAP] |=> (reg_q[IDX_TRAP] == ($past(wdata) & 32'h0000_07FF)));
  assert_fault_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[IDX_FAULT] |=> (reg_q[IDX_FAULT] == $past(wdata)));
endmodule

// File: rtl/mmu_crf_side.sv
module mmu_crf_side
  import mmu_crf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_sel,
  input  logic [DW-1:0]     wdata,
  input  logic [ASID_W-1:0] asid_q,
  output logic              tlb_inval,
  output logic              asid_flush
);
  logic inval_d, flush_d;

  assign inval_d = wr_sel[IDX_CTRL] && wdata[INVAL_BIT];
  assign flush_d = wr_sel[IDX_PTEH] && (wdata[ASID_W-1:0] != asid_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlb_inval  <= 1'b0;
      asid_flush <= 1'b0;
    end else begin
      tlb_inval  <= inval_d;
      asid_flush <= flush_d;
    end
  end

  // R4: a flush pulse only follows a real identifier change
  assert_flush_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    asid_flush |-> (asid_q != $past(asid_q)));
  // R11: no pulse without a write to its word in the previous cycle
  assert_inval_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval |-> $past(wr_sel[IDX_CTRL]));
endmodule

// File: rtl/mmu_crf.sv
module mmu_crf
  import mmu_crf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err,
  output logic              tlb_inval_pulse,
  output logic              asid_flush_pulse,
  output logic [31:0]       mmu_ctrl,
  output logic [31:0]       pte_high,
  output logic [31:0]       pte_low,
  output logic [31:0]       pte_assist,
  output logic [31:0]       table_base
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NREG-1:0]         wr_sel;
  logic [IDX_W-1:0]        rd_idx;
  logic                    rd_hit;
  logic [NREG-1:0][DW-1:0] reg_q;

  mmu_crf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_size (acc_size),
    .acc_addr (acc_addr),
    .wr_sel   (wr_sel),
    .rd_idx   (rd_idx),
    .rd_hit   (rd_hit),
    .acc_err  (acc_err)
  );

  mmu_crf_regs #(.IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .wdata  (acc_wdata),
    .rd_hit (rd_hit),
    .rd_idx (rd_idx),
    .reg_q  (reg_q),
    .rdata  (acc_rdata)
  );

  mmu_crf_side u_side (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (wr_sel),
    .wdata      (acc_wdata),
    .asid_q     (reg_q[IDX_PTEH][ASID_W-1:0]),
    .tlb_inval  (tlb_inval_pulse),
    .asid_flush (asid_flush_pulse)
  );

  assign mmu_ctrl   = reg_q[IDX_CTRL];
  assign pte_high   = reg_q[IDX_PTEH];
  assign pte_low    = reg_q[IDX_PTEL];
  assign pte_assist = reg_q[IDX_PTEA];
  assign table_base = reg_q[IDX_TBASE];

  assert_err_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == 32'h0));
  assert_err_no_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> $stable(reg_q));
  assert_inval_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval_pulse |-> (mmu_ctrl[INVAL_BIT] == 1'b0));
endmodule

// File: tb/mmu_crf_bench.sv
module mmu_crf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_size = 2'd2;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic        tlb_inval_pulse, asid_flush_pulse;
  logic [31:0] mmu_ctrl, pte_high, pte_low, pte_assist, table_base;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [9];

  always #4 clk = ~clk;

  mmu_crf u_mmu_crf (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err),
    .tlb_inval_pulse(tlb_inval_pulse), .asid_flush_pulse(asid_flush_pulse),
    .mmu_ctrl(mmu_ctrl), .pte_high(pte_high), .pte_low(pte_low),
    .pte_assist(pte_assist), .table_base(table_base)
  );

  function automatic logic [31:0] mask_of(input int idx);
    case (idx)
      0:       return 32'hFFFF_FFFB;
      3:       return 32'h0000_000F;
      6, 7, 8: return 32'h0000_07FF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input string rq);
    int  idx = int'(a >> 2);
    bit  legal = (a[1:0] == 2'b00) && (idx < 9) && (sz == 2'd2);
    bit  e_inv = legal && (idx == 0) && d[2];
    bit  e_fl  = legal && (idx == 1) && (d[7:0] != model[1][7:0]);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_size = sz; acc_addr = a; acc_wdata = d;
    #2;
    chk({rq, " err"}, 32'(acc_err), 32'(!legal));
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    if (legal) model[idx] = d & mask_of(idx);
    chk("R2 inval pulse", 32'(tlb_inval_pulse), 32'(e_inv));
    chk("R4 flush pulse", 32'(asid_flush_pulse), 32'(e_fl));
    @(negedge clk);
    chk("R11 inval width", 32'(tlb_inval_pulse), 32'd0);
    chk("R11 flush width", 32'(asid_flush_pulse), 32'd0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] sz, input string rq);
    int  idx = int'(a >> 2);
    bit  legal = (a[1:0] == 2'b00) && (idx < 9) && (sz == 2'd2);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_size = sz; acc_addr = a;
    #2;
    chk({rq, " rdata"}, acc_rdata, legal ? model[idx] : 32'h0);
    chk({rq, " err"}, 32'(acc_err), 32'(!legal));
    acc_en = 1'b0;
  endtask

  task automatic read_all(input string rq);
    for (int r = 0; r < 9; r++) do_read(8'(r * 4), 2'd2, rq);
    chk({rq, " ctrl pin"}, mmu_ctrl, model[0]);
    chk({rq, " pteh pin"}, pte_high, model[1]);
    chk({rq, " ptel pin"}, pte_low, model[2]);
    chk({rq, " ptea pin"}, pte_assist, model[3]);
    chk({rq, " tbase pin"}, table_base, model[4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 9; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 inval at reset", 32'(tlb_inval_pulse), 32'd0);
    chk("R1 flush at reset", 32'(asid_flush_pulse), 32'd0);
    read_all("R1 reset");

    // R5 R6 R7 R10: walking one and walking zero through every word
    for (int r = 0; r < 9; r++) begin
      for (int b = 0; b < 32; b++) begin
        do_write(8'(r * 4), 2'd2, 32'(1) << b, "R10 walk1");
        do_read(8'(r * 4), 2'd2, r == 3 ? "R5" : (r >= 6 ? "R6" : "R7"));
        do_write(8'(r * 4), 2'd2, ~(32'(1) << b), "R10 walk0");
        do_read(8'(r * 4), 2'd2, r == 3 ? "R5" : (r >= 6 ? "R6" : "R7"));
      end
    end

    // R2 R3: invalidate bit set / clear
    do_write(8'h00, 2'd2, 32'hFFFF_FFFF, "R2 all ones");
    do_read(8'h00, 2'd2, "R2 bit reads 0");
    do_write(8'h00, 2'd2, 32'h1234_5670 & 32'hFFFF_FFFB, "R3 no inval");
    do_read(8'h00, 2'd2, "R3");

    // R4: same identifier twice, then change only upper bits, then identifier
    do_write(8'h04, 2'd2, 32'hABCD_EF5A, "R4 set");
    do_write(8'h04, 2'd2, 32'hABCD_EF5A, "R4 repeat");
    do_write(8'h04, 2'd2, 32'h0000_005A, "R4 upper only");
    do_write(8'h04, 2'd2, 32'h0000_005B, "R4 change");
    read_all("R4");

    // R8: wrong sizes on every word, writes and reads
    for (int r = 0; r < 9; r++) begin
      for (int s = 0; s < 4; s++) begin
        if (s != 2) begin
          do_write(8'(r * 4), 2'(s), 32'hFFFF_FFFF, "R8 size wr");
          do_read(8'(r * 4), 2'(s), "R8 size rd");
        end
      end
    end
    read_all("R8 unchanged");

    // R9: misaligned offsets and offsets past the map
    for (int a = 1; a < 36; a++) begin
      if ((a % 4) != 0) begin
        do_write(8'(a), 2'd2, 32'hFFFF_FFFF, "R9 misaligned wr");
        do_read(8'(a), 2'd2, "R9 misaligned rd");
      end
    end
    for (int a = 36; a < 256; a += 4) begin
      do_write(8'(a), 2'd2, 32'hFFFF_FFFF, "R9 unmapped wr");
      do_read(8'(a), 2'd2, "R9 unmapped rd");
    end
    read_all("R9 unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule